// File: doc/BRIEF.md
# Micro-op Dispatch Stage Controller

This controller decides, one decoded instruction at a time, whether that instruction may enter the out-of-order backend. Each instruction arrives with its micro-op count, a load-capable flag, a store-capable flag, and flags marking it as zero-latency and dependency-breaking. The controller keeps a budget of free dispatch slots for the current dispatch group. A group begins on each clock where `grp_start` is high. An instruction that needs more micro-ops than the dispatch width can still be absorbed: it takes the whole group, and the remaining micro-ops are carried into the following groups. While those micro-ops are still pending, nothing else enters.

The backend resources are outside this block. Only their status enters as inputs: the free entries in the retire unit, a register-file busy mask, the load and store queue full flags, a scheduler-buffer unavailable flag and an in-order-resource reserved flag. When dispatch is refused, the controller reports one 3-bit stall cause, chosen by a fixed priority, in the same cycle. For each accepted instruction it also states whether destination registers must be allocated.

Top module: `uop_dispatch_ctrl`

## Requirements
- R1: After reset, `slots_free` equals the dispatch width DISP_W, `carry_left` is 0, and `stall_cause` is 0 while `in_valid` is low.
- R2: When an instruction with `in_uops` <= DISP_W is accepted, `accept` is high in the same cycle. On the next clock, `slots_free` becomes the cycle's effective slot count minus `in_uops`.
- R3: On a clock with `grp_start` high, let m = min(`carry_left`, DISP_W). The effective slot count for that clock is DISP_W - m, and the effective carry is `carry_left` - m. With no acceptance, these values are registered.
- R4: An instruction with `in_uops` > DISP_W is accepted only when the effective slot count equals DISP_W. Its acceptance sets `slots_free` to 0 and `carry_left` to `in_uops` - DISP_W. An instruction with exactly DISP_W micro-ops is handled as an ordinary one.
- R5: While the effective carry is nonzero, every valid instruction is refused with cause 1 (dispatch width).
- R6: An instruction of at most DISP_W micro-ops that needs more slots than are effectively free is refused with cause 1.
- R7: If `rcu_free` < `in_uops`, dispatch is refused with cause 2 (retire unit).
- R8: Any set bit in `prf_busy` refuses dispatch with cause 3 (register file). An all-zero mask allows dispatch.
- R9: A load-capable instruction (`in_may_load`) with `lq_full` high is refused with cause 4. `lq_full` has no effect on an instruction that is not load-capable.
- R10: A store-capable instruction (`in_may_store`) with `sq_full` high is refused with cause 5. `sq_full` has no effect on an instruction that is not store-capable.
- R11: `sched_unavail` refuses with cause 6 (scheduler full). `inorder_rsvd` refuses with cause 7 (dispatch group).
- R12: When several conditions hold, the reported cause is the one with the lowest code. The order is 1, then 2, 3, 4, 5, 6, 7. `accept` is high exactly when `in_valid` is high and the cause is 0.
- R13: `alloc_regs` is high for an accepted instruction unless both `in_zero_lat` and `in_dep_break` are high. It is low when nothing is accepted.
- R14: With `in_valid` low, `stall_cause` is 0, `accept` is low, and slot and carry state change only through a group start (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_start | input | 1 | First clock of a new dispatch group; refills slots |
| in_valid | input | 1 | Instruction presented |
| in_uops | input | UOP_W | Micro-op count of the instruction |
| in_may_load | input | 1 | Instruction may read memory |
| in_may_store | input | 1 | Instruction may write memory |
| in_zero_lat | input | 1 | Instruction has zero latency |
| in_dep_break | input | 1 | Instruction breaks register dependencies |
| rcu_free | input | RCU_W | Free micro-op entries in the retire unit |
| prf_busy | input | RF_N | Register-file unavailability mask, one bit per file |
| lq_full | input | 1 | Load queue full |
| sq_full | input | 1 | Store queue full |
| sched_unavail | input | 1 | Scheduler buffer unavailable |
| inorder_rsvd | input | 1 | In-order issue resource reserved |
| accept | output | 1 | Instruction enters the backend this cycle |
| stall_cause | output | 3 | Refusal cause, 0 when no stall |
| alloc_regs | output | 1 | Accepted instruction needs physical registers |
| slots_free | output | UOP_W | Registered free slot count |
| carry_left | output | UOP_W | Registered carried-over micro-op count |

## Verification
The registered slot count and carry are visible at `slots_free` and `carry_left`. A wrong update therefore appears at those ports one clock after the decision that caused it. From that clock on it also changes every later `accept` and cause-1 decision, because each decision compares against that state. A priority mistake in the refusal logic appears in the same cycle as the wrong `stall_cause` code. The bench sets up several refusal conditions at once so that the code that wins is visible.

// File: rtl/uop_dispatch_pkg.sv
package uop_dispatch_pkg;
  typedef enum logic [2:0] {
    STALL_NONE    = 3'd0,
    STALL_WIDTH   = 3'd1,
    STALL_RETIRE  = 3'd2,
    STALL_REGFILE = 3'd3,
    STALL_LOADQ   = 3'd4,
    STALL_STOREQ  = 3'd5,
    STALL_SCHED   = 3'd6,
    STALL_GROUP   = 3'd7
  } stall_e;
  localparam int NUM_CAUSES = 8;
endpackage

// File: rtl/uop_slot_tracker.sv
module uop_slot_tracker #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_start,
  input  logic             take,
  input  logic [UOP_W-1:0] uops,
  output logic [UOP_W-1:0] slots_q,
  output logic [UOP_W-1:0] carry_q,
  output logic             fits
);
  localparam logic [UOP_W-1:0] W_U = UOP_W'(DISP_W);

  logic [UOP_W-1:0] drain, eff_slots, eff_carry, slots_d, carry_d;
  logic             wide, upd_en;

  // Group refill: drain up to one full group of pending carry
  always_comb begin
    drain     = (carry_q > W_U) ? W_U : carry_q;
    eff_slots = grp_start ? (W_U - drain) : slots_q;
    eff_carry = grp_start ? (carry_q - drain) : carry_q;
    wide      = (uops > W_U);
    if (eff_carry != '0)
      fits = 1'b0;
    else if (wide)
      fits = (eff_slots == W_U);
    else
      fits = (uops <= eff_slots);
  end

  always_comb begin
    slots_d = eff_slots;
    carry_d = eff_carry;
    if (take) begin
      if (wide) begin
        slots_d = '0;
        carry_d = uops - W_U;
      end else begin
        slots_d = eff_slots - uops;
      end
    end
    upd_en = take | grp_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= W_U;
      carry_q <= '0;
    end else if (upd_en) begin
      slots_q <= slots_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/uop_stall_arbiter.sv
module uop_stall_arbiter
  import uop_dispatch_pkg::*;
#(
  parameter int NREQ = NUM_CAUSES
) (
  input  logic [NREQ-1:1] req,
  output stall_e          cause
);
  // Lowest-numbered active request wins
  always_comb begin
    cause = STALL_NONE;
    for (int i = NREQ - 1; i >= 1; i--) begin
      if (req[i]) cause = stall_e'(i[2:0]);
    end
  end
endmodule

// File: rtl/uop_dispatch_ctrl.sv
module uop_dispatch_ctrl
  import uop_dispatch_pkg::*;
#(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int RCU_W  = 6,
  parameter int RF_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_start,
  input  logic             in_valid,
  input  logic [UOP_W-1:0] in_uops,
  input  logic             in_may_load,
  input  logic             in_may_store,
  input  logic             in_zero_lat,
  input  logic             in_dep_break,
  input  logic [RCU_W-1:0] rcu_free,
  input  logic [RF_N-1:0]  prf_busy,
  input  logic             lq_full,
  input  logic             sq_full,
  input  logic             sched_unavail,
  input  logic             inorder_rsvd,
  output logic             accept,
  output logic [2:0]       stall_cause,
  output logic             alloc_regs,
  output logic [UOP_W-1:0] slots_free,
  output logic [UOP_W-1:0] carry_left
);
  localparam int CMP_W = (RCU_W > UOP_W) ? RCU_W : UOP_W;

  logic                  fits;
  logic [NUM_CAUSES-1:1] req;
  stall_e                cause;

  uop_slot_tracker #(.DISP_W(DISP_W), .UOP_W(UOP_W)) trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_start(grp_start),
    .take     (accept),
    .uops     (in_uops),
    .slots_q  (slots_free),
    .carry_q  (carry_left),
    .fits     (fits)
  );

  always_comb begin
    req[STALL_WIDTH]   = !fits;
    req[STALL_RETIRE]  = CMP_W'(rcu_free) < CMP_W'(in_uops);
    req[STALL_REGFILE] = |prf_busy;
    req[STALL_LOADQ]   = in_may_load & lq_full;
    req[STALL_STOREQ]  = in_may_store & sq_full;
    req[STALL_SCHED]   = sched_unavail;
    req[STALL_GROUP]   = inorder_rsvd;
  end

  uop_stall_arbiter #(.NREQ(NUM_CAUSES)) arb_i (
    .req  (req),
    .cause(cause)
  );

  always_comb begin
    accept      = in_valid && (cause == STALL_NONE);
    stall_cause = in_valid ? cause : STALL_NONE;
    alloc_regs  = accept && !(in_zero_lat && in_dep_break);
  end
endmodule

// File: rtl/uop_dispatch_chk.sv
module uop_dispatch_chk #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int RCU_W  = 6,
  parameter int RF_N   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grp_start,
  input logic             in_valid,
  input logic [UOP_W-1:0] in_uops,
  input logic [RCU_W-1:0] rcu_free,
  input logic [RF_N-1:0]  prf_busy,
  input logic             accept,
  input logic [2:0]       stall_cause,
  input logic             alloc_regs,
  input logic [UOP_W-1:0] slots_free,
  input logic [UOP_W-1:0] carry_left
);
  localparam logic [UOP_W-1:0] W_U = UOP_W'(DISP_W);

  p_slot_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slots_free <= W_U);

  p_small_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_uops <= W_U && !grp_start)
      |=> slots_free == $past(slots_free) - $past(in_uops));

  p_wide_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_uops > W_U)
      |=> (slots_free == '0) && (carry_left == $past(in_uops) - W_U));

  p_carry_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_left != '0 && !grp_start) |-> stall_cause == 3'd1);

  p_rcu_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (32'(rcu_free) < 32'(in_uops))) |-> !accept);

  p_prf_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|prf_busy)) |-> !accept);

  p_accept_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (accept == (stall_cause == 3'd0)));

  p_alloc_needs_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_regs |-> accept);

  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (stall_cause == 3'd0 && !accept));

  p_idle_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !grp_start) |=> ($stable(slots_free) && $stable(carry_left)));
endmodule

bind uop_dispatch_ctrl uop_dispatch_chk #(
  .DISP_W(DISP_W), .UOP_W(UOP_W), .RCU_W(RCU_W), .RF_N(RF_N)
) chk_i (.*);

// File: tb/uop_dispatch_ctrl_tb_top.sv
module uop_dispatch_ctrl_tb_top;
  localparam int DISP_W = 4;
  localparam int UOP_W  = 4;
  localparam int RCU_W  = 6;
  localparam int RF_N   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grp_start = 0, in_valid = 0, in_may_load = 0, in_may_store = 0;
  logic in_zero_lat = 0, in_dep_break = 0, lq_full = 0, sq_full = 0;
  logic sched_unavail = 0, inorder_rsvd = 0;
  logic [UOP_W-1:0] in_uops = '0;
  logic [RCU_W-1:0] rcu_free = '0;
  logic [RF_N-1:0]  prf_busy = '0;
  logic accept, alloc_regs;
  logic [2:0] stall_cause;
  logic [UOP_W-1:0] slots_free, carry_left;

  always #2 clk = ~clk;

  uop_dispatch_ctrl #(.DISP_W(DISP_W), .UOP_W(UOP_W), .RCU_W(RCU_W), .RF_N(RF_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .grp_start(grp_start), .in_valid(in_valid),
    .in_uops(in_uops), .in_may_load(in_may_load), .in_may_store(in_may_store),
    .in_zero_lat(in_zero_lat), .in_dep_break(in_dep_break), .rcu_free(rcu_free),
    .prf_busy(prf_busy), .lq_full(lq_full), .sq_full(sq_full),
    .sched_unavail(sched_unavail), .inorder_rsvd(inorder_rsvd),
    .accept(accept), .stall_cause(stall_cause), .alloc_regs(alloc_regs),
    .slots_free(slots_free), .carry_left(carry_left)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // scoreboard queues
  logic       q_acc[$];
  logic [2:0] q_cause[$];
  logic       q_alloc[$];
  int         q_slots[$];
  int         q_carry[$];
  string      q_tag[$];

  // reference state, from the requirements
  int m_slots = DISP_W;
  int m_carry = 0;

  task automatic step(input bit gs, input bit v, input int u,
                      input bit ld, input bit st, input bit zl, input bit db,
                      input int rcu, input int prf, input bit lqf, input bit sqf,
                      input bit sch, input bit rsv, input string tag);
    int mdr, es, ec, cs;
    bit wide, fit, acc;
    @(posedge clk);
    #1;
    grp_start = gs; in_valid = v; in_uops = UOP_W'(u);
    in_may_load = ld; in_may_store = st; in_zero_lat = zl; in_dep_break = db;
    rcu_free = RCU_W'(rcu); prf_busy = RF_N'(prf);
    lq_full = lqf; sq_full = sqf; sched_unavail = sch; inorder_rsvd = rsv;
    mdr  = (m_carry < DISP_W) ? m_carry : DISP_W;
    es   = gs ? DISP_W - mdr : m_slots;
    ec   = gs ? m_carry - mdr : m_carry;
    wide = (u > DISP_W);
    fit  = (ec == 0) && (wide ? (es == DISP_W) : (u <= es));
    if (!v)              cs = 0;
    else if (!fit)       cs = 1;
    else if (rcu < u)    cs = 2;
    else if (prf != 0)   cs = 3;
    else if (ld && lqf)  cs = 4;
    else if (st && sqf)  cs = 5;
    else if (sch)        cs = 6;
    else if (rsv)        cs = 7;
    else                 cs = 0;
    acc = v && (cs == 0);
    q_acc.push_back(acc);
    q_cause.push_back(3'(cs));
    q_alloc.push_back(acc && !(zl && db));
    q_slots.push_back(m_slots);
    q_carry.push_back(m_carry);
    q_tag.push_back(tag);
    if (acc) begin
      if (wide) begin m_slots = 0; m_carry = u - DISP_W; end
      else begin m_slots = es - u; m_carry = ec; end
    end else begin
      m_slots = es; m_carry = ec;
    end
  endtask

  // monitor: comb outputs and current state, mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q_tag.size() > 0) begin
        logic ea, eal; logic [2:0] ec; int es, ecr; string t;
        ea = q_acc.pop_front(); ec = q_cause.pop_front(); eal = q_alloc.pop_front();
        es = q_slots.pop_front(); ecr = q_carry.pop_front(); t = q_tag.pop_front();
        n_tests++;
        if (accept !== ea || stall_cause !== ec || alloc_regs !== eal ||
            int'(slots_free) != es || int'(carry_left) != ecr) begin
          n_fail++;
          $display("FAIL %s: act acc=%0b cause=%0d alloc=%0b slots=%0d carry=%0d exp acc=%0b cause=%0d alloc=%0b slots=%0d carry=%0d",
                   t, accept, stall_cause, alloc_regs, slots_free, carry_left,
                   ea, ec, eal, es, ecr);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //      gs v  u  ld st zl db rcu prf lq sq sc rs
    step(0, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R1 reset state idle");
    step(1, 1, 2, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R2 accept 2 uops");
    step(0, 1, 3, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R6 too few slots");
    step(0, 1, 2, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R2 fill remaining slots");
    step(0, 1, 1, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R6 zero slots left");
    step(1, 1, 10, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R4 wide instruction");
    step(0, 1, 1, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R5 carry blocks");
    step(1, 1, 1, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R3 R5 drain, carry still pending");
    step(1, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R3 final drain partial group");
    step(0, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R14 idle holds state");
    step(0, 1, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 retire unit short");
    step(0, 1, 2, 1, 0, 0, 0, 32, 1, 1, 0, 0, 0, "R8 R12 regfile over loadq");
    step(0, 1, 2, 0, 0, 0, 0, 32, 2, 0, 0, 0, 0, "R8 regfile upper bit");
    step(0, 1, 2, 1, 1, 0, 0, 32, 0, 1, 1, 1, 1, "R9 R12 loadq wins");
    step(0, 1, 2, 0, 1, 0, 0, 32, 0, 1, 1, 1, 1, "R10 store queue");
    step(0, 1, 2, 0, 0, 0, 0, 32, 0, 1, 1, 1, 1, "R11 R9 R10 scheduler full");
    step(0, 1, 2, 0, 0, 0, 0, 32, 0, 0, 0, 0, 1, "R11 in-order reserved");
    step(0, 1, 1, 0, 0, 1, 1, 32, 0, 1, 1, 0, 0, "R13 R9 R10 no alloc, queues ignored");
    step(0, 1, 1, 0, 0, 1, 0, 32, 0, 0, 0, 0, 0, "R13 zero-lat alone allocates");
    step(0, 1, 1, 0, 0, 0, 0, 0, 3, 1, 1, 1, 1, "R12 width wins over all");
    step(1, 1, 4, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R4 exactly width is ordinary");
    step(0, 1, 5, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R4 wide refused without full group");
    step(1, 1, 5, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R4 wide accepted on full group");
    step(0, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R4 carry one left");
    step(1, 1, 3, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R3 refill minus carry");
    step(1, 1, 15, 0, 0, 0, 0, 15, 0, 0, 0, 0, 0, "R4 max width instruction");
    step(1, 1, 15, 0, 0, 0, 0, 14, 0, 0, 0, 0, 0, "R5 carry blocks on group start");
    step(1, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R3 drain");
    step(1, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R3 drain last");
    step(0, 0, 0, 0, 0, 0, 0, 32, 0, 0, 0, 0, 0, "R3 R14 settled");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule